// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block models the command front end of a byte-wide parallel NOR flash. It watches single-cycle bus writes (address, data, write strobe), recognises the multi-write command sequences the flash accepts, and runs simplified embedded program and chip-erase operations on a small register-based array. Busy time is a fixed number of clock cycles, set per operation by a parameter.

While an operation runs, reads return a status byte instead of array data: the top bit is the inverse of the top bit of the byte being written, and the next bit flips on every read. A host polls these bits to find out when the operation is over. An unlock bypass mode shortens each program to two writes, and an asynchronous hardware reset cuts off any running operation.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, `busy` and `rdata_vld` are 0, and reads return the stored array bytes.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, then data D at address A start a program. `busy` goes high at the clock edge of the last write and stays high for exactly PROG_CYCLES cycles.
- R3: A program stores the old byte AND D, so bits can only go from 1 to 0. Any address can be programmed, in any order.
- R4: The writes AAh@555h, 55h@2AAh, 20h@555h enter bypass mode. In bypass mode, a write of A0h at any address followed by a write of D at address A programs A. The mode stays active after the operation ends.
- R5: In bypass mode, any write other than A0h or 90h has no effect. This includes complete unlock, program and erase sequences.
- R6: In bypass mode, 90h followed by 00h (any addresses) returns the block to read mode. After that, a lone A0h followed by a data write programs nothing.
- R7: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h start a chip erase. It is busy for exactly ERASE_CYCLES cycles and leaves every byte at FFh.
- R8: Every write issued while `busy` is high is ignored.
- R9: A read taken while busy returns, on bit 7, the inverse of bit 7 of the target data (FFh for erase), and on bit 6 a toggle bit. The toggle is 0 on the first read after the operation starts and flips on each later busy read. Bits 5:0 read as 0.
- R10: Driving `rst_n` low clears `busy` at once, leaves the target byte unchanged, and leaves bypass mode.
- R11: In read mode, a wrong address or data value anywhere in a sequence sends the decoder back to read mode, and the partial sequence starts nothing.
- R12: `rdata_vld` is high exactly in the cycle after each `rd_en` cycle, and `rdata` holds the result during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| addr | input | ADDR_W | Bus address; low bits index the array |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Array byte or status byte |
| rdata_vld | output | 1 | Read result valid |
| busy | output | 1 | Embedded operation in progress |

## Verification
The assertions rely on three things about the inputs: each bus write lasts one cycle, a read and a write never start an operation in the same cycle, and nothing reads the array before the first chip erase has given it defined contents. The bench follows all three. It drives strobes for one cycle from the falling edge, never raises both strobes together, and opens with a chip erase. It issues status reads only well inside a busy window, so a read is never answered in the cycle where the operation finishes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
   typedef enum logic [3:0] {
      ST_READ, ST_UNL1, ST_UNL2, ST_PGM,
      ST_ERS_SET, ST_ERS_UNL1, ST_ERS_UNL2,
      ST_BYP, ST_BYP_PGM, ST_BYP_EXIT
   } seq_state_e;

   typedef enum logic [1:0] { OP_NONE, OP_PROG, OP_ERASE } op_kind_e;

   localparam int KEY_W = 11;
   localparam logic [KEY_W-1:0] KEY_ADDR_A = 11'h555;
   localparam logic [KEY_W-1:0] KEY_ADDR_B = 11'h2AA;

   localparam logic [7:0] C_UNLOCK_A  = 8'hAA;
   localparam logic [7:0] C_UNLOCK_B  = 8'h55;
   localparam logic [7:0] C_PROGRAM   = 8'hA0;
   localparam logic [7:0] C_ERASE_SET = 8'h80;
   localparam logic [7:0] C_CHIP_ERS  = 8'h10;
   localparam logic [7:0] C_BYP_ENTER = 8'h20;
   localparam logic [7:0] C_BYP_LEAVE = 8'h90;
   localparam logic [7:0] C_BYP_CONF  = 8'h00;
endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   output logic              start_prog,
   output logic              start_erase
);
   seq_state_e state_q, state_d;
   logic       wr_ok;
   logic [KEY_W-1:0] key;
   logic [7:0] cmd;

   assign wr_ok = wr_en && !busy;
   assign key   = addr[KEY_W-1:0];
   assign cmd   = wdata[7:0];

   always_comb begin
      state_d     = state_q;
      start_prog  = 1'b0;
      start_erase = 1'b0;
      if (wr_ok) begin
         unique case (state_q)
            ST_READ:
               if (key == KEY_ADDR_A && cmd == C_UNLOCK_A) state_d = ST_UNL1;
            ST_UNL1:
               state_d = (key == KEY_ADDR_B && cmd == C_UNLOCK_B) ? ST_UNL2 : ST_READ;
            ST_UNL2: begin
               state_d = ST_READ;
               if (key == KEY_ADDR_A) begin
                  if (cmd == C_PROGRAM)        state_d = ST_PGM;
                  else if (cmd == C_ERASE_SET) state_d = ST_ERS_SET;
                  else if (cmd == C_BYP_ENTER) state_d = ST_BYP;
               end
            end
            ST_PGM: begin
               start_prog = 1'b1;
               state_d    = ST_READ;
            end
            ST_ERS_SET:
               state_d = (key == KEY_ADDR_A && cmd == C_UNLOCK_A) ? ST_ERS_UNL1 : ST_READ;
            ST_ERS_UNL1:
               state_d = (key == KEY_ADDR_B && cmd == C_UNLOCK_B) ? ST_ERS_UNL2 : ST_READ;
            ST_ERS_UNL2: begin
               state_d = ST_READ;
               if (key == KEY_ADDR_A && cmd == C_CHIP_ERS) start_erase = 1'b1;
            end
            ST_BYP:
               if (cmd == C_PROGRAM)        state_d = ST_BYP_PGM;
               else if (cmd == C_BYP_LEAVE) state_d = ST_BYP_EXIT;
            ST_BYP_PGM: begin
               start_prog = 1'b1;
               state_d    = ST_BYP;
            end
            ST_BYP_EXIT:
               state_d = (cmd == C_BYP_CONF) ? ST_READ : ST_BYP;
            default: state_d = ST_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_READ;
      else        state_q <= state_d;
   end

   // R5: foreign writes keep bypass mode as it is
   assert_bypass_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BYP && wr_en && !busy && wdata[7:0] != C_PROGRAM &&
       wdata[7:0] != C_BYP_LEAVE) |=> state_q == ST_BYP);

   // R6: confirmed exit lands in read mode
   assert_bypass_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BYP_EXIT && wr_en && !busy && wdata[7:0] == C_BYP_CONF)
      |=> state_q == ST_READ);
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
   import flash_cmd_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int IDX_W        = 5,
   parameter int PROG_CYCLES  = 8,
   parameter int ERASE_CYCLES = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_prog,
   input  logic              start_erase,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              prog_commit,
   output logic              erase_commit,
   output logic [IDX_W-1:0]  tgt_idx,
   output logic [DATA_W-1:0] tgt_data
);
   localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   logic [CNT_W-1:0] cnt_q;
   op_kind_e         kind_q;
   logic             last;

   assign last         = busy && (cnt_q == '0);
   assign prog_commit  = last && (kind_q == OP_PROG);
   assign erase_commit = last && (kind_q == OP_ERASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt_q    <= '0;
         kind_q   <= OP_NONE;
         tgt_idx  <= '0;
         tgt_data <= '0;
      end else if (!busy) begin
         if (start_prog) begin
            busy     <= 1'b1;
            cnt_q    <= CNT_W'(PROG_CYCLES - 1);
            kind_q   <= OP_PROG;
            tgt_idx  <= wr_idx;
            tgt_data <= wr_data;
         end else if (start_erase) begin
            busy     <= 1'b1;
            cnt_q    <= CNT_W'(ERASE_CYCLES - 1);
            kind_q   <= OP_ERASE;
            tgt_idx  <= '0;
            tgt_data <= '1;
         end
      end else if (last) begin
         busy   <= 1'b0;
         kind_q <= OP_NONE;
         if (kind_q == OP_ERASE) tgt_idx <= '0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // R2: busy only drops once the countdown is spent
   assert_busy_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(cnt_q) == '0);
endmodule

// File: rtl/flash_byte_store.sv
module flash_byte_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_commit,
   input  logic              erase_commit,
   input  logic [IDX_W-1:0]  prog_idx,
   input  logic [DATA_W-1:0] prog_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word
);
   logic [DATA_W-1:0] words [DEPTH];
   logic [DATA_W-1:0] cur_word;

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (erase_commit)
            word_q <= '1;
         else if (prog_commit && prog_idx == IDX_W'(i))
            word_q <= word_q & prog_data;
      end
      assign words[i] = word_q;
   end

   assign rd_word  = (32'(rd_idx)   < DEPTH) ? words[rd_idx]   : '1;
   assign cur_word = (32'(prog_idx) < DEPTH) ? words[prog_idx] : '1;

   // R3: a program never raises a bit
   assert_prog_clears_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      prog_commit |=> (cur_word & ~$past(cur_word)) == '0);

   // R7: erase leaves ones behind
   assert_erase_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      erase_commit |=> cur_word == '1);
endmodule

// File: rtl/flash_status_read.sv
module flash_status_read #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              busy,
   input  logic              op_start,
   input  logic              tgt_msb,
   input  logic [DATA_W-1:0] arr_word,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_vld
);
   logic              tog_q;
   logic [DATA_W-1:0] stat_word;

   assign stat_word = {~tgt_msb, tog_q, {(DATA_W-2){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q     <= 1'b0;
         rdata     <= '0;
         rdata_vld <= 1'b0;
      end else begin
         rdata_vld <= rd_en;
         if (op_start)          tog_q <= 1'b0;
         else if (rd_en && busy) tog_q <= ~tog_q;
         if (rd_en) rdata <= busy ? stat_word : arr_word;
      end
   end

   // R9: polling bit is the inverse of the target msb
   assert_poll_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_vld && $past(rd_en && busy)) |-> rdata[DATA_W-1] == ~$past(tgt_msb));

   // R12: valid follows the read strobe by one cycle
   assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rdata_vld);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
   parameter int ADDR_W       = 11,
   parameter int DATA_W       = 8,
   parameter int DEPTH        = 32,
   parameter int PROG_CYCLES  = 8,
   parameter int ERASE_CYCLES = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_vld,
   output logic              busy
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (ADDR_W < flash_cmd_pkg::KEY_W) begin : g_chk_addr
      $error("ADDR_W must cover the unlock key addresses");
   end
   if (DATA_W < 8) begin : g_chk_data
      $error("DATA_W must hold an 8-bit command");
   end
   if (IDX_W > ADDR_W) begin : g_chk_depth
      $error("DEPTH exceeds the address space");
   end
   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_chk_cyc
      $error("busy durations must be at least one cycle");
   end

   logic              start_prog, start_erase;
   logic              prog_commit, erase_commit;
   logic [IDX_W-1:0]  tgt_idx;
   logic [DATA_W-1:0] tgt_data;
   logic [DATA_W-1:0] arr_word;

   flash_seq_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .busy(busy), .start_prog(start_prog), .start_erase(start_erase)
   );

   flash_op_engine #(.DATA_W(DATA_W), .IDX_W(IDX_W),
      .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_eng (
      .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
      .wr_idx(addr[IDX_W-1:0]), .wr_data(wdata), .busy(busy),
      .prog_commit(prog_commit), .erase_commit(erase_commit),
      .tgt_idx(tgt_idx), .tgt_data(tgt_data)
   );

   flash_byte_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .prog_commit(prog_commit), .erase_commit(erase_commit),
      .prog_idx(tgt_idx), .prog_data(tgt_data), .rd_idx(addr[IDX_W-1:0]),
      .rd_word(arr_word)
   );

   flash_status_read #(.DATA_W(DATA_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy),
      .op_start(start_prog || start_erase), .tgt_msb(tgt_data[DATA_W-1]),
      .arr_word(arr_word), .rdata(rdata), .rdata_vld(rdata_vld)
   );

   // R8: no new operation may begin inside a busy window
   assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !prog_commit && !erase_commit) |=> busy && $stable(tgt_data));
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
   localparam int ADDR_W = 11, DATA_W = 8, DEPTH = 32, PC = 8, EC = 20;
   localparam int IDX_W = $clog2(DEPTH);

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic rdata_vld, busy;

   flash_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
      .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld), .busy(busy)
   );

   always #4 clk = ~clk;

   int n_tests = 0, n_fail = 0;
   logic [7:0] model [DEPTH];
   logic [7:0] exp_q [$];
   string      tag_q [$];
   int run_len = 0, last_run = 0;
   bit saw_busy = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: scoreboard pop and busy-window measurement
   always @(negedge clk) begin
      if (!rst_n) begin
         run_len = 0;
      end else begin
         if (busy) begin
            run_len++;
            saw_busy = 1;
         end else if (run_len != 0) begin
            last_run = run_len;
            run_len  = 0;
         end
         if (rdata_vld) begin
            if (exp_q.size() == 0) begin
               check(0, "R12 unexpected valid", 32'(rdata), 0);
            end else begin
               automatic logic [7:0] e = exp_q.pop_front();
               automatic string t = tag_q.pop_front();
               check(rdata == e, t, 32'(rdata), 32'(e));
            end
         end
      end
   end

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_expect(input logic [ADDR_W-1:0] a, input logic [7:0] e,
                            input string tag);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic drain();
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic unlock();
      bus_write(11'h555, 8'hAA);
      bus_write(11'h2AA, 8'h55);
   endtask

   task automatic chip_erase();
      unlock(); bus_write(11'h555, 8'h80);
      unlock(); bus_write(11'h555, 8'h10);
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
   endtask

   task automatic std_prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      unlock(); bus_write(11'h555, 8'hA0); bus_write(a, d);
      model[a[IDX_W-1:0]] = model[a[IDX_W-1:0]] & d;
   endtask

   task automatic quiet_check(input string tag);
      repeat (3) @(negedge clk);
      check(saw_busy == 0, tag, 32'(saw_busy), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      check(busy == 0, "R1 busy in reset", 32'(busy), 0);
      check(rdata_vld == 0, "R1 valid in reset", 32'(rdata_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 0, "R1 busy after reset", 32'(busy), 0);

      // R7 chip erase with R9 status polling
      chip_erase();
      rd_expect(11'h003, 8'h00, "R9 erase poll first");
      rd_expect(11'h003, 8'h40, "R9 erase poll second");
      wait_idle();
      check(last_run == EC, "R7 erase duration", 32'(last_run), EC);
      for (int i = 0; i < DEPTH; i++) rd_expect(ADDR_W'(i), model[i], "R7 erased byte");
      drain();

      // R2 standard program with R9 polling
      std_prog(11'h013, 8'h5A);
      rd_expect(11'h013, 8'h80, "R9 prog poll first");
      rd_expect(11'h013, 8'hC0, "R9 prog poll second");
      rd_expect(11'h013, 8'h80, "R9 prog poll third");
      wait_idle();
      check(last_run == PC, "R2 program duration", 32'(last_run), PC);
      rd_expect(11'h013, model[5'h13], "R2 programmed byte");
      drain();

      // R3 AND semantics and arbitrary order
      std_prog(11'h013, 8'hF0); wait_idle();
      rd_expect(11'h013, 8'h50, "R3 and with stored");
      std_prog(11'h007, 8'h3C); wait_idle();
      std_prog(11'h013, 8'hFF); wait_idle();
      rd_expect(11'h007, model[7], "R3 lower address later");
      rd_expect(11'h013, 8'h50, "R3 ones do not restore");
      drain();

      // R11 broken sequence
      saw_busy = 0;
      bus_write(11'h555, 8'hAA);
      bus_write(11'h2AB, 8'h55);
      bus_write(11'h555, 8'hA0);
      bus_write(11'h009, 8'h00);
      quiet_check("R11 broken sequence busy");
      rd_expect(11'h009, 8'hFF, "R11 byte untouched");
      drain();

      // R4 bypass entry and short programs
      unlock(); bus_write(11'h555, 8'h20);
      bus_write(11'h000, 8'hA0); bus_write(11'h01E, 8'h0F);
      model[5'h1E] = 8'h0F;
      wait_idle();
      check(last_run == PC, "R4 bypass program duration", 32'(last_run), PC);
      bus_write(11'h123, 8'hA0); bus_write(11'h01E, 8'h11);
      model[5'h1E] = 8'h01;
      wait_idle();
      rd_expect(11'h01E, 8'h01, "R4 second bypass program");
      drain();

      // R5 foreign writes in bypass
      saw_busy = 0;
      unlock(); bus_write(11'h555, 8'h80);
      unlock(); bus_write(11'h555, 8'h10);
      unlock(); bus_write(11'h555, 8'h55); bus_write(11'h01E, 8'h00);
      quiet_check("R5 bypass ignores erase");
      rd_expect(11'h01E, 8'h01, "R5 byte kept");
      drain();

      // R6 bypass exit
      bus_write(11'h000, 8'h90); bus_write(11'h000, 8'h00);
      saw_busy = 0;
      bus_write(11'h555, 8'hA0); bus_write(11'h002, 8'h00);
      quiet_check("R6 no program after exit");
      rd_expect(11'h002, 8'hFF, "R6 byte untouched");
      drain();

      // R8 writes during erase ignored
      chip_erase();
      unlock(); bus_write(11'h555, 8'hA0); bus_write(11'h005, 8'h00);
      wait_idle();
      check(last_run == EC, "R8 erase not disturbed", 32'(last_run), EC);
      rd_expect(11'h005, 8'hFF, "R8 program during busy ignored");
      drain();

      // R10 hardware reset abort from bypass mode
      unlock(); bus_write(11'h555, 8'h20);
      bus_write(11'h000, 8'hA0); bus_write(11'h00A, 8'h00);
      check(busy == 1, "R10 program started", 32'(busy), 1);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(busy == 0, "R10 busy cleared at once", 32'(busy), 0);
      @(negedge clk);
      rst_n = 1'b1;
      saw_busy = 0;
      rd_expect(11'h00A, 8'hFF, "R10 target unchanged");
      bus_write(11'h000, 8'hA0); bus_write(11'h00A, 8'h00);
      quiet_check("R10 bypass left");
      rd_expect(11'h00A, 8'hFF, "R10 byte still erased");
      drain();
      check(exp_q.size() == 0, "R12 pending reads", 32'(exp_q.size()), 0);
      check(rdata_vld == 0, "R12 valid idle", 32'(rdata_vld), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule